// File: doc/BRIEF.md
# Bus Reset Responder

This block is the reset-handling part of a bus peripheral that can be both a master and a slave. When the shared bus reset line (`bus_init_i`) goes high, the block first lets any transfer already under way run to its end. For a read-with-pause, that includes the paired write that must follow the read. It then lets go of bus mastership. It drops the non-processor request, the four priority request levels and the selection acknowledge. From then on it passes every incoming grant straight on to the devices further down the chain, and it clears its interrupt-enable bit.

When the bus reset line goes low again, the block counts through an internal initialization window and reports busy for that time. A command strobe that arrives while the block is busy, or while the bus reset is high, is thrown away and sets a sticky rejected flag. The error flag keeps its value through a bus reset. The data transfer engine supplies the transfer start/done pulses and the raw request wishes. Register decoding lives elsewhere.

Top module: `bus_reset_responder`

## Requirements
- R1: If a single transfer (kind 2'b00 or 2'b01) is in flight when the bus reset rises, `bbsy_o` stays high until the edge that samples `xfer_done_i`, and is low after that edge.
- R2: For a read-with-pause transfer (kind 2'b10), the first `xfer_done_i` ends the read phase. `wr_pending_o` and `bbsy_o` then stay high until a second `xfer_done_i`, even while the bus reset is high.
- R3: One edge after the bus reset is sampled high, `npr_o`, all bits of `br_o` and `sack_o` are low, and they stay low while it remains high.
- R4: Grant bit 0 is the non-processor grant and bits 4:1 are priority levels 4 to 7, matching `{br_o, npr_o}`. While the bus reset is high, `grant_o` equals `grant_i` delayed by one edge. Otherwise a grant is passed on only at levels where the device's registered request is low.
- R5: The bus reset clears `ie_o` on the next edge, and `err_o` keeps its value.
- R6: `busy_o` is high while the bus reset is high. It goes low at the INIT_CYCLES-th edge counted from the first edge that samples the reset low, with that first edge counted as the first.
- R7: A `cmd_valid_i` sampled while busy or in bus reset leaves `ie_o` unchanged and sets `rej_o`. `rej_o` stays high until `rej_clr_i` is sampled, and a new rejection in the same cycle wins over the clear.
- R8: While the bus reset is high, a `xfer_start_i` is ignored. With no transfer in flight, `bbsy_o` is low one edge after the bus reset is sampled.
- R9: Outside bus reset, `npr_o`, `br_o`, `sack_o` and `bbsy_o` follow their request inputs with one edge of delay, and a command accepted when not busy loads `ie_o` from `cmd_ie_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high chip reset |
| bus_init_i | input | 1 | Bus reset line |
| xfer_start_i | input | 1 | Transfer engine starts a transfer |
| xfer_kind_i | input | 2 | Kind of the started transfer: 00 read, 01 write, 10 read-with-pause |
| xfer_done_i | input | 1 | Current transfer phase finished |
| bbsy_want_i | input | 1 | Engine wishes to hold mastership |
| npr_want_i | input | 1 | Engine wishes a non-processor request |
| br_want_i | input | 4 | Engine wishes priority requests, levels 4..7 |
| sack_want_i | input | 1 | Engine wishes to drive selection acknowledge |
| grant_i | input | 5 | Incoming grants {levels 7..4, non-processor} |
| cmd_valid_i | input | 1 | Command strobe from the register side |
| cmd_ie_i | input | 1 | Interrupt-enable value carried by the command |
| err_set_i | input | 1 | Sets the error flag |
| rej_clr_i | input | 1 | Clears the rejected flag |
| bbsy_o | output | 1 | Mastership busy drive |
| npr_o | output | 1 | Non-processor request drive |
| br_o | output | 4 | Priority request drives, levels 4..7 |
| sack_o | output | 1 | Selection acknowledge drive |
| grant_o | output | 5 | Outgoing grants to the next device |
| wr_pending_o | output | 1 | Paired write of a read-with-pause still owed |
| ie_o | output | 1 | Interrupt-enable bit |
| err_o | output | 1 | Error flag |
| rej_o | output | 1 | Sticky command-rejected flag |
| busy_o | output | 1 | Initialization busy status |

## Verification
If the transfer tracker drops into idle too early, `bbsy_o` falls before the second done pulse of a read-with-pause, one edge after the first pulse. If the tracker hangs, `bbsy_o` stays up after the final pulse. A request register that ignores the bus reset shows up one edge after the reset is sampled, as a live request level or as a blocked grant at that level. A wrong initialization count moves the falling edge of `busy_o` by exactly the count error. A bad acceptance gate shows as a changed `ie_o` or a missing `rej_o` one edge after the strobe.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
  typedef enum logic [1:0] {
    KIND_READ    = 2'b00,
    KIND_WRITE   = 2'b01,
    KIND_RDPAUSE = 2'b10,
    KIND_RSVD    = 2'b11
  } xfer_kind_t;

  typedef enum logic [1:0] {
    XS_IDLE   = 2'b00,
    XS_SINGLE = 2'b01,
    XS_RP_RD  = 2'b10,
    XS_RP_WR  = 2'b11
  } xfer_state_t;
endpackage

// File: rtl/rrc_xfer_track.sv
module rrc_xfer_track
  import rrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       block_i,
  input  logic       start_i,
  input  logic [1:0] kind_i,
  input  logic       done_i,
  output logic       active_nxt_o,
  output logic       wr_pend_o
);
  xfer_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      XS_IDLE:   if (start_i && !block_i)
                   state_d = (xfer_kind_t'(kind_i) == KIND_RDPAUSE) ? XS_RP_RD : XS_SINGLE;
      XS_SINGLE: if (done_i) state_d = XS_IDLE;
      XS_RP_RD:  if (done_i) state_d = XS_RP_WR;
      XS_RP_WR:  if (done_i) state_d = XS_IDLE;
      default:   state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= XS_IDLE;
    else     state_q <= state_d;
  end

  assign active_nxt_o = (state_d != XS_IDLE);
  assign wr_pend_o    = (state_q == XS_RP_WR);

  AST_PAIR_WRITE_OWED: assert property (@(posedge clk) disable iff (rst)
    (state_q == XS_RP_RD) && done_i |=> wr_pend_o); // R2

  AST_NO_START_IN_INIT: assert property (@(posedge clk) disable iff (rst)
    (state_q == XS_IDLE) && block_i |=> (state_q == XS_IDLE)); // R8
endmodule

// File: rtl/rrc_req_gate.sv
module rrc_req_gate #(
  parameter int NUM_BR = 4,
  localparam int LINES = NUM_BR + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_i,
  input  logic [LINES-1:0] want_i,
  input  logic             sack_want_i,
  input  logic [LINES-1:0] grant_i,
  output logic [LINES-1:0] req_o,
  output logic             sack_o,
  output logic [LINES-1:0] grant_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        req_o[g]   <= 1'b0;
        grant_o[g] <= 1'b0;
      end else begin
        req_o[g]   <= want_i[g] & ~init_i;
        grant_o[g] <= grant_i[g] & (init_i | ~req_o[g]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sack_o <= 1'b0;
    else     sack_o <= sack_want_i & ~init_i;
  end

  AST_REQ_QUIET_IN_INIT: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(init_i) |-> (req_o == '0) && !sack_o); // R3

  AST_GRANT_FORCED: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(init_i) |-> (grant_o == $past(grant_i))); // R4
endmodule

// File: rtl/rrc_init_timer.sv
module rrc_init_timer #(
  parameter int INIT_CYCLES = 8,
  localparam int CNT_W = $clog2(INIT_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic init_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_o <= 1'b0;
    end else if (init_i) begin
      cnt_q  <= CNT_W'(INIT_CYCLES);
      busy_o <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - 1'b1;
      busy_o <= (cnt_q != CNT_W'(1));
    end
  end

  AST_BUSY_DURING_INIT: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(init_i) |-> busy_o); // R6

  AST_BUSY_ONLY_FALLS: assert property (@(posedge clk) disable iff (rst)
    !$past(init_i) && !$past(busy_o) |-> !busy_o); // R6
endmodule

// File: rtl/bus_reset_responder.sv
module bus_reset_responder #(
  parameter int NUM_BR      = 4,
  parameter int INIT_CYCLES = 8,
  localparam int LINES = NUM_BR + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_init_i,
  input  logic              xfer_start_i,
  input  logic [1:0]        xfer_kind_i,
  input  logic              xfer_done_i,
  input  logic              bbsy_want_i,
  input  logic              npr_want_i,
  input  logic [NUM_BR-1:0] br_want_i,
  input  logic              sack_want_i,
  input  logic [LINES-1:0]  grant_i,
  input  logic              cmd_valid_i,
  input  logic              cmd_ie_i,
  input  logic              err_set_i,
  input  logic              rej_clr_i,
  output logic              bbsy_o,
  output logic              npr_o,
  output logic [NUM_BR-1:0] br_o,
  output logic              sack_o,
  output logic [LINES-1:0]  grant_o,
  output logic              wr_pending_o,
  output logic              ie_o,
  output logic              err_o,
  output logic              rej_o,
  output logic              busy_o
);
  logic             active_nxt;
  logic [LINES-1:0] req_q;

  rrc_xfer_track u_track (
    .clk          (clk),
    .rst          (rst),
    .block_i      (bus_init_i),
    .start_i      (xfer_start_i),
    .kind_i       (xfer_kind_i),
    .done_i       (xfer_done_i),
    .active_nxt_o (active_nxt),
    .wr_pend_o    (wr_pending_o)
  );

  rrc_req_gate #(.NUM_BR(NUM_BR)) u_gate (
    .clk         (clk),
    .rst         (rst),
    .init_i      (bus_init_i),
    .want_i      ({br_want_i, npr_want_i}),
    .sack_want_i (sack_want_i),
    .grant_i     (grant_i),
    .req_o       (req_q),
    .sack_o      (sack_o),
    .grant_o     (grant_o)
  );

  rrc_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .init_i (bus_init_i),
    .busy_o (busy_o)
  );

  assign npr_o = req_q[0];
  assign br_o  = req_q[LINES-1:1];

  // Mastership is kept only as long as a transfer is still owed.
  always_ff @(posedge clk) begin
    if (rst) bbsy_o <= 1'b0;
    else     bbsy_o <= active_nxt | (bbsy_want_i & ~bus_init_i);
  end

  logic cmd_refused;
  assign cmd_refused = cmd_valid_i & (busy_o | bus_init_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_o  <= 1'b0;
      err_o <= 1'b0;
      rej_o <= 1'b0;
    end else begin
      if (bus_init_i)                 ie_o <= 1'b0;
      else if (cmd_valid_i && !busy_o) ie_o <= cmd_ie_i;
      if (err_set_i)                  err_o <= 1'b1;
      if (cmd_refused)                rej_o <= 1'b1;
      else if (rej_clr_i)             rej_o <= 1'b0;
    end
  end

  AST_IE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(bus_init_i) |-> !ie_o); // R5

  AST_ERR_KEPT: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(err_o) |-> err_o); // R5

  AST_REJ_STICKY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(rej_o) && !$past(rej_clr_i) |-> rej_o); // R7

  AST_IE_HELD_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(busy_o) && !$past(bus_init_i) |-> ie_o == $past(ie_o)); // R7
endmodule

// File: tb/sim_bus_reset_responder.sv
module sim_bus_reset_responder;
  localparam int NB = 4;
  localparam int NL = NB + 1;
  localparam int N_INIT = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, bus_init, xs, xd, bw, nw, sw, cv, cie, es, rc;
  logic [1:0] xk;
  logic [NB-1:0] brw, br;
  logic [NL-1:0] gi, go;
  logic bbsy, npr, sack, wp, ie, err, rej, busy;

  bus_reset_responder #(.NUM_BR(NB), .INIT_CYCLES(N_INIT)) u0 (
    .clk(clk), .rst(rst), .bus_init_i(bus_init), .xfer_start_i(xs),
    .xfer_kind_i(xk), .xfer_done_i(xd), .bbsy_want_i(bw), .npr_want_i(nw),
    .br_want_i(brw), .sack_want_i(sw), .grant_i(gi), .cmd_valid_i(cv),
    .cmd_ie_i(cie), .err_set_i(es), .rej_clr_i(rc), .bbsy_o(bbsy),
    .npr_o(npr), .br_o(br), .sack_o(sack), .grant_o(go),
    .wr_pending_o(wp), .ie_o(ie), .err_o(err), .rej_o(rej), .busy_o(busy)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // {init, npr, br[3:0], sack, gin[4:0], e_npr, e_br[3:0], e_sack, e_gnt[4:0]}
  localparam logic [22:0] VEC [6] = '{
    {1'b0, 1'b1, 4'b0101, 1'b0, 5'b11111, 1'b1, 4'b0101, 1'b0, 5'b10100},
    {1'b1, 1'b1, 4'b0101, 1'b0, 5'b11111, 1'b0, 4'b0000, 1'b0, 5'b11111},
    {1'b0, 1'b0, 4'b1000, 1'b1, 5'b01001, 1'b0, 4'b1000, 1'b1, 5'b01001},
    {1'b1, 1'b1, 4'b1111, 1'b1, 5'b10110, 1'b0, 4'b0000, 1'b0, 5'b10110},
    {1'b0, 1'b1, 4'b1111, 1'b1, 5'b11111, 1'b1, 4'b1111, 1'b1, 5'b00000},
    {1'b0, 1'b0, 4'b0000, 1'b0, 5'b00110, 1'b0, 4'b0000, 1'b0, 5'b00110}
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; bus_init = 0; xs = 0; xk = 2'b00; xd = 0; bw = 0; nw = 0; sw = 0;
    brw = '0; gi = '0; cv = 0; cie = 0; es = 0; rc = 0;
    @(negedge clk); step(); step(); step();
    rst = 0;
    step();
    // reset state
    chk("R3 reset", {3'b0, npr, br}, 8'h00);
    chk("R4 reset", {3'b0, go}, 8'h00);
    chk("R6 reset", {6'b0, busy, bbsy}, 8'h00);
    chk("R7 reset", {5'b0, ie, err, rej}, 8'h00);

    // vector table: R3 R4 R9
    for (int i = 0; i < 6; i++) begin
      logic [22:0] v;
      v = VEC[i];
      bus_init = v[22]; nw = v[21]; brw = v[20:17]; sw = v[16]; gi = v[15:11];
      step(); step();
      chk(v[22] ? "R3 vec" : "R9 vec", {2'b0, npr, br, sack}, {2'b0, v[10], v[9:6], v[5]});
      chk("R4 vec", {3'b0, go}, {3'b0, v[4:0]});
    end
    bus_init = 0; nw = 0; brw = '0; sw = 0; gi = '0;
    repeat (N_INIT + 2) step();

    // R9: mastership follows wish outside reset
    bw = 1; step();
    chk("R9 bbsy follow", {7'b0, bbsy}, 8'h01);

    // R1: single transfer in flight across reset
    xs = 1; xk = 2'b00; step(); xs = 0;
    bus_init = 1; step();
    chk("R1 held", {7'b0, bbsy}, 8'h01);
    step();
    chk("R1 held2", {7'b0, bbsy}, 8'h01);
    xd = 1; step(); xd = 0;
    chk("R1 released", {6'b0, wp, bbsy}, 8'h00);

    // R8: start during reset is ignored
    xs = 1; step(); xs = 0; step();
    chk("R8 no start", {7'b0, bbsy}, 8'h00);

    // R5: error survives, ie cleared (ie was 0; set it after busy)
    bus_init = 0; bw = 0;
    // R6: busy window after release
    for (int k = 0; k < N_INIT - 1; k++) begin
      step();
      chk("R6 busy window", {7'b0, busy}, 8'h01);
      if (k == 2) begin
        // R7: command while busy
        cv = 1; cie = 1; step(); cv = 0; k++;
        chk("R7 ie kept", {7'b0, ie}, 8'h00);
        chk("R7 rej set", {7'b0, rej}, 8'h01);
      end
    end
    step();
    chk("R6 busy end", {7'b0, busy}, 8'h00);
    rc = 1; step(); rc = 0;
    chk("R7 rej clear", {7'b0, rej}, 8'h00);
    cv = 1; cie = 1; step(); cv = 0;
    chk("R9 cmd accept", {6'b0, ie, rej}, 8'h02);
    es = 1; step(); es = 0;
    bus_init = 1; step();
    chk("R5 ie clr err kept", {6'b0, ie, err}, 8'h01);
    cv = 1; rc = 1; step(); cv = 0; rc = 0;
    chk("R7 rej wins", {7'b0, rej}, 8'h01);

    // R2: read-with-pause crossing reset
    bus_init = 0; repeat (N_INIT + 1) step();
    bw = 1; xs = 1; xk = 2'b10; step(); xs = 0;
    bus_init = 1; bw = 0;
    xd = 1; step(); xd = 0;
    chk("R2 pair owed", {6'b0, wp, bbsy}, 8'h03);
    step();
    chk("R2 pair held", {6'b0, wp, bbsy}, 8'h03);
    xd = 1; step(); xd = 0;
    chk("R2 pair done", {6'b0, wp, bbsy}, 8'h00);
    bus_init = 0; step();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule